// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in memory. A request brings the virtual address and the base of the top-level table. The walker splits the virtual page number into two 10-bit indices and reads the top-level entry first. If that entry is present, it reads the second-level entry from the table it points to. It then answers with the frame number from that second entry joined to the unchanged 12-bit page offset. If either entry is absent, the walk stops at once and the walker answers with a fault instead of an address.

Requests and responses each use a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. Only one walk is in flight, so `req_ready` stays low until the response has been taken. The response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low the walker holds the response unchanged, with no limit on the wait.

Memory reads are one-cycle pulses on `mem_rd_en`. Each read is answered later by a single `mem_rd_valid` pulse, after any number of cycles. Table entries are 32 bits wide:
- bit 0 marks the entry as present;
- bits 31:12 hold a frame number or the base of the next table;
- bit 1, the modified flag, and bits 11:2 are not used by the walk.

Top module: `pt_walker`

## Requirements
- R1: While reset is active and on the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays 0 until the response handshake completes. No memory read is issued while `req_ready` is 1.
- R3: The first read goes to address `{req_root[31:12], 12'h000} + vaddr[31:22]*4`. Bits 11:0 of `req_root` have no effect.
- R4: When the top-level entry has bit 0 set, the second read goes to address `{entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R5: When both entries have bit 0 set, the response carries `rsp_fault`=0 and `rsp_paddr` = `{leaf_entry[31:12], vaddr[11:0]}`.
- R6: When the top-level entry has bit 0 clear, the response carries `rsp_fault`=1 and `rsp_paddr`=0, after exactly one memory read.
- R7: When the top-level entry is present but the second-level entry has bit 0 clear, the response carries `rsp_fault`=1 and `rsp_paddr`=0, after exactly two memory reads.
- R8: Bit 1 (modified) and bits 11:2 of either entry have no effect on the read addresses or on the result.
- R9: The walker waits any number of cycles for `mem_rd_valid` on each read, and the result does not depend on that latency.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_fault` and `rsp_paddr` hold their values.
- R11: `mem_rd_en` is high for exactly one cycle per read, and a walk issues at most one read per level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the top-level table (low 12 bits ignored) |
| rsp_valid | output | 1 | A response is offered |
| rsp_ready | input | 1 | The consumer takes the response |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Page fault: an entry was not present |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Byte address of the table entry to read |
| mem_rd_valid | input | 1 | Read data is valid this cycle |
| mem_rd_data | input | 32 | Table entry returned by memory |

## Verification
The assertions assume that memory answers each read with exactly one `mem_rd_valid` pulse. They also assume that no `mem_rd_valid` pulse arrives unless a read is outstanding. The bench memory model follows this rule: it holds at most one pending read, returns it once after a latency chosen for each request, and stays silent otherwise. The assertions make no assumption about how long `rsp_ready` stays low. The bench therefore varies the back-pressure from none to several cycles, and it holds `req_valid` low whenever `req_ready` is low.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  // Walk sequencer states; the order of the walk is the order of the encodings.
  typedef enum logic [2:0] {
    WS_IDLE       = 3'd0,
    WS_TOP_ISSUE  = 3'd1,
    WS_TOP_WAIT   = 3'd2,
    WS_LEAF_ISSUE = 3'd3,
    WS_LEAF_WAIT  = 3'd4,
    WS_DONE       = 3'd5,
    WS_FAULT      = 3'd6
  } walk_state_e;

  // Number of table levels walked per translation.
  localparam int unsigned NUM_LEVELS = 2;

endpackage

// File: rtl/pt_entry_addr.sv
// Computes the byte address of one table entry from a table base frame and an index.
module pt_entry_addr #(
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int ENT_SH = 2
) (
  input  logic [PA_W-OFF_W-1:0] tbl_frame,
  input  logic [IDX_W-1:0]      idx,
  output logic [PA_W-1:0]       ent_addr
);
  localparam int PAD_W = PA_W - IDX_W;

  logic [PA_W-1:0] base_bytes;
  logic [PA_W-1:0] idx_bytes;

  always_comb begin
    base_bytes = {tbl_frame, {OFF_W{1'b0}}};
    idx_bytes  = {{PAD_W{1'b0}}, idx} << ENT_SH;
    ent_addr   = base_bytes + idx_bytes;
  end
endmodule

// File: rtl/pt_entry_dec.sv
// Splits a table entry into its present flag and frame field.
module pt_entry_dec #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic [PA_W-1:0]       entry,
  output logic                  present,
  output logic [PA_W-OFF_W-1:0] frame
);
  // The modified flag and the reserved bits play no part in a walk.
  logic unused_entry_bits;

  always_comb begin
    present           = entry[0];
    frame             = entry[PA_W-1:OFF_W];
    unused_entry_bits = ^entry[OFF_W-1:1];
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk sequencer: one request at a time, with an early exit on an absent entry.
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        rd_valid,
  input  logic        entry_present,
  input  logic        rsp_fire,
  output walk_state_e state
);
  walk_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      WS_IDLE:       if (req_fire) state_nx = WS_TOP_ISSUE;
      WS_TOP_ISSUE:  state_nx = WS_TOP_WAIT;
      WS_TOP_WAIT:   if (rd_valid) state_nx = entry_present ? WS_LEAF_ISSUE : WS_FAULT;
      WS_LEAF_ISSUE: state_nx = WS_LEAF_WAIT;
      WS_LEAF_WAIT:  if (rd_valid) state_nx = entry_present ? WS_DONE : WS_FAULT;
      WS_DONE,
      WS_FAULT:      if (rsp_fire) state_nx = WS_IDLE;
      default:       state_nx = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker: top-level read, then leaf read, then frame joined with offset.
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] req_root,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            mem_rd_en,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [PA_W-1:0] mem_rd_data
);
  localparam int FR_W   = PA_W - OFF_W;
  localparam int ENT_SH = $clog2(PA_W / 8);

  walk_state_e state;
  logic        req_fire;
  logic        rsp_fire;
  logic        ent_present;
  logic [FR_W-1:0] ent_frame;

  logic [VA_W-1:0] vaddr_q;
  logic [FR_W-1:0] tbl_q [NUM_LEVELS];
  logic [FR_W-1:0] frame_q;
  logic [IDX_W-1:0] lvl_idx  [NUM_LEVELS];
  logic [PA_W-1:0]  lvl_addr [NUM_LEVELS];
  logic unused_root_bits;

  assign req_fire         = req_valid && req_ready;
  assign rsp_fire         = rsp_valid && rsp_ready;
  assign unused_root_bits = ^req_root[OFF_W-1:0];

  pt_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_fire      (req_fire),
    .rd_valid      (mem_rd_valid),
    .entry_present (ent_present),
    .rsp_fire      (rsp_fire),
    .state         (state)
  );

  pt_entry_dec #(.PA_W(PA_W), .OFF_W(OFF_W)) u_dec (
    .entry   (mem_rd_data),
    .present (ent_present),
    .frame   (ent_frame)
  );

  // One index slice and one entry-address adder per level; level 0 takes the highest index bits.
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
    localparam int LSB = OFF_W + (NUM_LEVELS - 1 - g) * IDX_W;
    assign lvl_idx[g] = vaddr_q[LSB +: IDX_W];
    pt_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SH(ENT_SH)) u_addr (
      .tbl_frame (tbl_q[g]),
      .idx       (lvl_idx[g]),
      .ent_addr  (lvl_addr[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q  <= '0;
      tbl_q[0] <= '0;
      tbl_q[1] <= '0;
      frame_q  <= '0;
    end else begin
      if (req_fire) begin
        vaddr_q  <= req_vaddr;
        tbl_q[0] <= req_root[PA_W-1:OFF_W];
      end
      if (state == WS_TOP_WAIT && mem_rd_valid && ent_present)
        tbl_q[1] <= ent_frame;
      if (state == WS_LEAF_WAIT && mem_rd_valid && ent_present)
        frame_q <= ent_frame;
    end
  end

  always_comb begin
    req_ready   = (state == WS_IDLE);
    mem_rd_en   = (state == WS_TOP_ISSUE) || (state == WS_LEAF_ISSUE);
    mem_rd_addr = (state == WS_LEAF_ISSUE) ? lvl_addr[1] : lvl_addr[0];
    rsp_valid   = (state == WS_DONE) || (state == WS_FAULT);
    rsp_fault   = (state == WS_FAULT);
    rsp_paddr   = (state == WS_DONE) ? {frame_q, vaddr_q[OFF_W-1:0]} : '0;
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic            mem_rd_en
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      off_q <= '0;
    else if (req_valid && req_ready) off_q <= req_vaddr[OFF_W-1:0];
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_no_accept_with_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_no_read_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);
  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_q));
  assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
  assert_read_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .mem_rd_en (mem_rd_en)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_root = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #10 clk = ~clk;

  pt_walker u0 (.*);

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    bit          fault;
    logic [31:0] paddr;
    int          reads;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] mem [logic [31:0]];
  int lat_sel = 0;
  int bp_cycles = 0;
  int rd_cnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Reference walk per R3..R8.
  task automatic model(input logic [31:0] va, input logic [31:0] root,
                       output bit f, output logic [31:0] pa, output int n);
    logic [31:0] e1, e2;
    e1 = rd({root[31:12], 12'h0} + {20'h0, va[31:22], 2'b00});
    n = 1; f = 1'b1; pa = '0;
    if (!e1[0]) return;
    e2 = rd({e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00});
    n = 2;
    if (!e2[0]) return;
    f = 1'b0;
    pa = {e2[31:12], va[11:0]};
  endtask

  // Memory responder: one pending read, answered after lat_sel extra cycles.
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          lat_cnt = 0;
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_en) begin
      rd_cnt    <= rd_cnt + 1;
      pend      <= 1'b1;
      pend_addr <= mem_rd_addr;
      lat_cnt   <= lat_sel;
    end else if (pend) begin
      if (lat_cnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= rd(pend_addr);
        pend         <= 1'b0;
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
  end

  // Driver: pushes the expected result, then offers the request.
  task automatic translate(input logic [31:0] va, input logic [31:0] root,
                           input int lat, input int bp, input string tag);
    exp_t e;
    while (!req_ready) @(negedge clk);
    model(va, root, e.fault, e.paddr, e.reads);
    e.tag = tag;
    exp_q.push_back(e);
    lat_sel = lat;
    bp_cycles = bp;
    req_vaddr = va;
    req_root = root;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 ready low after accept", {31'h0, req_ready}, 32'h0);
  endtask

  // Monitor: pops and compares each response, applying back-pressure first.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        for (int i = 0; i < bp_cycles; i++) begin
          rsp_ready = 1'b0;
          @(negedge clk);
          check(rsp_valid == 1'b1, "R10 response held", {31'h0, rsp_valid}, 32'h1);
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected response", rsp_paddr, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(rsp_fault == e.fault, {e.tag, " fault"}, {31'h0, rsp_fault}, {31'h0, e.fault});
          check(rsp_paddr == e.paddr, {e.tag, " paddr"}, rsp_paddr, e.paddr);
          check(rd_cnt == e.reads, "R11 reads per walk", rd_cnt, e.reads);
        end
        rd_cnt = 0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Tables: root at 0x0001_0000.
    mem[32'h0001_0004] = 32'h0002_0001;             // top idx 1 -> leaf table 0x20000
    mem[32'h0002_000C] = 32'h000A_B001;             // leaf idx 3 -> frame 0xAB
    mem[32'h0001_0000] = 32'h0003_0FFF;             // top idx 0, modified and junk bits set (R8)
    mem[32'h0003_0000] = 32'h1234_5FFF;             // leaf idx 0, modified and junk bits set (R8)
    mem[32'h0001_0FFC] = 32'h0004_0001;             // top idx 1023
    mem[32'h0004_0FFC] = 32'hFFFF_F001;             // leaf idx 1023
    mem[32'h0001_0008] = 32'h0005_0002;             // top idx 2, absent with modified set (R6)
    mem[32'h0001_000C] = 32'h0006_0001;             // top idx 3 present
    mem[32'h0006_0010] = 32'h0007_7002;             // leaf idx 4 absent (R7)

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", {31'h0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_rd_en == 1'b0, "R1 no read after reset", {31'h0, mem_rd_en}, 32'h0);
    check(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);

    translate(32'h0040_3ABC, 32'h0001_0000, 0, 0, "R5 R4 basic walk");
    translate(32'h0040_3ABC, 32'h0001_0FFF, 2, 1, "R3 root low bits ignored");
    translate(32'h0000_0123, 32'h0001_0000, 1, 0, "R8 ignored entry bits");
    translate(32'hFFFF_FFFF, 32'h0001_0000, 5, 3, "R4 top index extremes");
    translate(32'h0080_0777, 32'h0001_0000, 0, 2, "R6 top absent");
    translate(32'h00C0_4555, 32'h0001_0000, 3, 0, "R7 leaf absent");
    translate(32'h0100_0000, 32'h0001_0000, 0, 0, "R6 unmapped top entry");
    translate(32'h0040_3001, 32'h0001_0000, 9, 0, "R9 long latency");
    translate(32'h0000_0FFE, 32'h0001_0000, 0, 4, "R10 back-pressure");

    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule